// File: doc/BRIEF.md
# Timekeeping Register Space with Consistent Read Snapshot

This block is the register space that sits behind a serial-bus slave in a real-time clock. The space is 64 bytes. Indexes 0 to 7 are the time, calendar and control bytes, and indexes 8 to 63 are general-purpose RAM. A bit-level protocol engine drives the bus side. It provides strobes for transaction start and stop, a pointer load, and byte read and write accesses. Each access moves the register pointer forward by one.

Time bytes are never read straight from the running counters. A user copy of all eight bytes is loaded from the live counter bus at three events:
- a bus start;
- a bus stop;
- the pointer wrapping from the last RAM byte back to index 0.

A burst read of the time therefore returns one coherent instant while the counters keep ticking.

Writes to the time bytes update the user copy. They also emit a one-cycle load strobe carrying the byte index and value, so the counter block can take the new setting.

Top module: `rtc_regfile`

## Requirements
- R1: `rd_data_o` always shows the byte at the current pointer. Pointer values 0 to 7 select the user time copy and values 8 to 63 select RAM. The output updates in the same cycle the pointer or the addressed byte changes.
- R2: A `ptr_load_i` cycle sets the pointer to `ptr_val_i` and suppresses any read or write asserted in that cycle. Otherwise each cycle with `rd_en_i` or `wr_en_i` advances the pointer by one, and 63 is followed by 0.
- R3: On a clock edge with `bus_start_i` or `bus_stop_i` high, all eight user time bytes take `live_time_i`. Byte k is bits [8k+7:8k].
- R4: An access that advances the pointer from 63 to 0 loads the user time copy from `live_time_i` on that same edge.
- R5: Apart from the events in R3, R4 and R6, the user time copy holds its value, even while `live_time_i` changes during a burst.
- R6: A write with the pointer in 0 to 7 stores the byte into the user copy. On the following cycle `tload_o` is high for exactly one cycle, with `tload_addr_o` equal to the pointer and `tload_data_o` equal to the written byte. In all other cycles `tload_o` is low.
- R7: A write with the pointer in 8 to 63 stores the byte in RAM. RAM bytes are not changed by snapshot events.
- R8: After reset the pointer is 0, the user time copy is all zero and `tload_o` is low, so `rd_data_o` reads 00h.
- R9: When a time write and a snapshot event fall on the same edge, the written byte keeps the written value and the other seven bytes take `live_time_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_start_i | input | 1 | Bus start event strobe |
| bus_stop_i | input | 1 | Bus stop event strobe |
| ptr_load_i | input | 1 | Load the register pointer |
| ptr_val_i | input | 6 | New pointer value |
| wr_en_i | input | 1 | Byte write at the pointer, then advance |
| wr_data_i | input | 8 | Byte to write |
| rd_en_i | input | 1 | Byte read consumed, advance pointer |
| rd_data_o | output | 8 | Byte at the current pointer |
| live_time_i | input | 64 | Live counter bytes, byte k at [8k+7:8k] |
| tload_o | output | 1 | One-cycle strobe: new time byte for counters |
| tload_addr_o | output | 3 | Time byte index for the strobe |
| tload_data_o | output | 8 | Time byte value for the strobe |

## Verification
Every state change lands on the rising edge where its stimulus is sampled. The pointer, the user copy and RAM change on that edge. `rd_data_o` is a combinational view of that state, so it is valid after the same edge. The `tload_o` group is registered, so it shows up after the edge that took the write and is gone one edge later.

The bench drives inputs on the falling edge and steps its behavioural model on the rising edge. It compares every output at the following falling edge. This puts each result exactly one edge after its stimulus. Because of the two-stage reset release, the bench also keeps the bus idle for several cycles after reset before it starts driving.

// File: rtl/rtc_rf_pkg.sv
package rtc_rf_pkg;
  parameter int unsigned ADDR_W     = 6;
  parameter int unsigned DATA_W     = 8;
  parameter int unsigned TIME_BYTES = 8;

  localparam int unsigned SPACE     = 1 << ADDR_W;
  localparam int unsigned RAM_BYTES = SPACE - TIME_BYTES;
  localparam int unsigned TIME_AW   = $clog2(TIME_BYTES);
  localparam int unsigned TIME_W    = TIME_BYTES * DATA_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam addr_t TIME_END = addr_t'(TIME_BYTES);
  localparam addr_t PTR_LAST = addr_t'(SPACE - 1);
endpackage

// File: rtl/rtc_rf_ptr.sv
module rtc_rf_ptr
  import rtc_rf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  addr_t load_val_i,
  input  logic  step_i,
  output addr_t ptr_o,
  output logic  wrap_o
);
  addr_t ptr_q, ptr_d;
  logic  ptr_en;

  always_comb begin
    ptr_en = load_i | step_i;
    ptr_d  = load_i ? load_val_i : addr_t'(ptr_q + 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o  = ptr_q;
  assign wrap_o = step_i & ~load_i & (ptr_q == PTR_LAST);
endmodule

// File: rtl/rtc_rf_shadow.sv
module rtc_rf_shadow
  import rtc_rf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               snap_i,
  input  logic [TIME_W-1:0]  live_i,
  input  logic               wr_i,
  input  logic [TIME_AW-1:0] wr_idx_i,
  input  byte_t              wr_data_i,
  output logic [TIME_W-1:0]  shadow_o,
  output logic               tload_o,
  output logic [TIME_AW-1:0] tload_addr_o,
  output byte_t              tload_data_o
);
  logic [TIME_W-1:0]     sh_q, sh_d;
  logic [TIME_BYTES-1:0] byte_wr;
  logic                  tl_q;
  logic [TIME_AW-1:0]    ta_q;
  byte_t                 td_q;

  for (genvar k = 0; k < TIME_BYTES; k++) begin : g_sel
    assign byte_wr[k] = wr_i & (wr_idx_i == TIME_AW'(k));
  end

  always_comb begin
    sh_d = sh_q;
    for (int k = 0; k < TIME_BYTES; k++) begin
      if (byte_wr[k])  sh_d[k*DATA_W +: DATA_W] = wr_data_i;
      else if (snap_i) sh_d[k*DATA_W +: DATA_W] = live_i[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (snap_i | wr_i) sh_q <= sh_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tl_q <= 1'b0;
    else         tl_q <= wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ta_q <= '0;
      td_q <= '0;
    end else if (wr_i) begin
      ta_q <= wr_idx_i;
      td_q <= wr_data_i;
    end
  end

  assign shadow_o     = sh_q;
  assign tload_o      = tl_q;
  assign tload_addr_o = ta_q;
  assign tload_data_o = td_q;
endmodule

// File: rtl/rtc_rf_ram.sv
module rtc_rf_ram
  import rtc_rf_pkg::*;
(
  input  logic  clk_i,
  input  logic  we_i,
  input  addr_t idx_i,
  input  byte_t wdata_i,
  output byte_t rdata_o
);
  byte_t mem_q [RAM_BYTES];
  localparam addr_t DEPTH = addr_t'(RAM_BYTES);

  always_ff @(posedge clk_i) begin
    if (we_i && idx_i < DEPTH) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = (idx_i < DEPTH) ? mem_q[idx_i] : '0;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_rf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_start_i,
  input  logic               bus_stop_i,
  input  logic               ptr_load_i,
  input  logic [ADDR_W-1:0]  ptr_val_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [TIME_W-1:0]  live_time_i,
  output logic               tload_o,
  output logic [TIME_AW-1:0] tload_addr_o,
  output logic [DATA_W-1:0]  tload_data_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n;
  logic              access, wr_acc, in_time, wrap, snap;
  addr_t             ptr_q, ram_idx;
  byte_t             ram_rdata;
  logic [TIME_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  always_comb begin
    access  = (rd_en_i | wr_en_i) & ~ptr_load_i;
    wr_acc  = wr_en_i & ~ptr_load_i;
    in_time = ptr_q < TIME_END;
    snap    = bus_start_i | bus_stop_i | wrap;
    ram_idx = addr_t'(ptr_q - TIME_END);
  end

  rtc_rf_ptr u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (ptr_load_i),
    .load_val_i (ptr_val_i),
    .step_i     (access),
    .ptr_o      (ptr_q),
    .wrap_o     (wrap)
  );

  rtc_rf_shadow u_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .snap_i       (snap),
    .live_i       (live_time_i),
    .wr_i         (wr_acc & in_time),
    .wr_idx_i     (ptr_q[TIME_AW-1:0]),
    .wr_data_i    (wr_data_i),
    .shadow_o     (shadow_q),
    .tload_o      (tload_o),
    .tload_addr_o (tload_addr_o),
    .tload_data_o (tload_data_o)
  );

  rtc_rf_ram u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_acc & ~in_time),
    .idx_i   (ram_idx),
    .wdata_i (wr_data_i),
    .rdata_o (ram_rdata)
  );

  assign rd_data_o = in_time ? shadow_q[ptr_q[TIME_AW-1:0]*DATA_W +: DATA_W] : ram_rdata;
endmodule

// File: rtl/rtc_rf_checker.sv
module rtc_rf_checker
  import rtc_rf_pkg::*;
(
  input logic               clk_i,
  input logic               rst_n,
  input logic               start_i,
  input logic               stop_i,
  input logic               load_i,
  input addr_t              load_val_i,
  input logic               wr_i,
  input logic               rd_i,
  input byte_t              wr_data_i,
  input logic [TIME_W-1:0]  live_i,
  input addr_t              ptr_i,
  input logic [TIME_W-1:0]  shadow_i,
  input logic               tload_i,
  input logic [TIME_AW-1:0] taddr_i,
  input byte_t              tdata_i
);
  logic acc, twr, wrp;
  assign acc = !load_i && (rd_i || wr_i);
  assign twr = !load_i && wr_i && (ptr_i < TIME_END);
  assign wrp = acc && (ptr_i == PTR_LAST);

  a_r2_load_sets_ptr: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_i |=> ptr_i == $past(load_val_i));

  a_r2_access_steps_ptr: assert property (@(posedge clk_i) disable iff (!rst_n)
    acc |=> ptr_i == addr_t'($past(ptr_i) + 1'b1));

  a_r2_idle_holds_ptr: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!load_i && !rd_i && !wr_i) |=> $stable(ptr_i));

  a_r3_bus_event_snapshot: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((start_i || stop_i) && !twr) |=> shadow_i == $past(live_i));

  a_r4_wrap_snapshot: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrp |=> shadow_i == $past(live_i));

  a_r5_shadow_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!start_i && !stop_i && !wrp && !twr) |=> $stable(shadow_i));

  a_r6_load_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    twr |=> tload_i && taddr_i == $past(ptr_i[TIME_AW-1:0]) && tdata_i == $past(wr_data_i));

  a_r6_strobe_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    !twr |=> !tload_i);
endmodule

bind rtc_regfile rtc_rf_checker u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .start_i    (bus_start_i),
  .stop_i     (bus_stop_i),
  .load_i     (ptr_load_i),
  .load_val_i (ptr_val_i),
  .wr_i       (wr_en_i),
  .rd_i       (rd_en_i),
  .wr_data_i  (wr_data_i),
  .live_i     (live_time_i),
  .ptr_i      (ptr_q),
  .shadow_i   (shadow_q),
  .tload_i    (tload_o),
  .taddr_i    (tload_addr_o),
  .tdata_i    (tload_data_o)
);

// File: tb/rtc_regfile_tb_top.sv
`timescale 1ns/1ps
module rtc_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st = 0, sp = 0, ld = 0, wr = 0, rd = 0;
  logic [5:0]  pv = '0;
  logic [7:0]  wd = '0;
  logic [63:0] live = 64'h0;
  logic        tick_en = 0;
  logic [7:0]  rdat, tdat;
  logic        tl;
  logic [2:0]  tadr;

  int checks = 0, fails = 0;
  bit done = 0, cmp_en = 0;

  int   m_ptr;
  logic [7:0] m_sh [8];
  logic [7:0] m_ram [64];
  bit   m_ok [64];
  bit   m_tl;
  int   m_ta;
  logic [7:0] m_td;
  bit   m_acc, m_tw, m_snap;

  always #5 clk = ~clk;

  rtc_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_start_i(st), .bus_stop_i(sp),
    .ptr_load_i(ld), .ptr_val_i(pv), .wr_en_i(wr), .wr_data_i(wd),
    .rd_en_i(rd), .rd_data_o(rdat), .live_time_i(live),
    .tload_o(tl), .tload_addr_o(tadr), .tload_data_o(tdat)
  );

  function automatic logic [7:0] ram_init(int a);
    return 8'((a * 7 + 3) % 256);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0;
      m_tl  = 0;
      for (int k = 0; k < 8; k++) m_sh[k] = 8'h00;
    end else begin
      m_acc  = !ld && (rd || wr);
      m_tw   = !ld && wr && m_ptr < 8;
      m_snap = st || sp || (m_acc && m_ptr == 63);
      m_tl   = 0;
      if (m_snap)
        for (int k = 0; k < 8; k++)
          if (!(m_tw && k == m_ptr)) m_sh[k] = live[k*8 +: 8];
      if (m_tw) begin
        m_sh[m_ptr] = wd; m_tl = 1; m_ta = m_ptr; m_td = wd;
      end
      if (!ld && wr && m_ptr >= 8) begin
        m_ram[m_ptr] = wd; m_ok[m_ptr] = 1;
      end
      if (ld) m_ptr = int'(pv);
      else if (m_acc) m_ptr = (m_ptr + 1) % 64;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      if (m_ptr < 8)        chk(rdat, m_sh[m_ptr], "R5 time byte");
      else if (m_ok[m_ptr]) chk(rdat, m_ram[m_ptr], "R1 ram byte");
      chk({7'b0, tl}, {7'b0, m_tl}, "R6 strobe");
      if (m_tl) begin
        chk({5'b0, tadr}, 8'(m_ta), "R6 strobe addr");
        chk(tdat, m_td, "R6 strobe data");
      end
    end
  end

  always @(negedge clk) if (tick_en) live <= live + 64'h0101_0101_0101_0103;

  task automatic step(input bit s_st, input bit s_sp, input bit s_ld, input logic [5:0] s_pv,
                      input bit s_wr, input logic [7:0] s_wd, input bit s_rd);
    st = s_st; sp = s_sp; ld = s_ld; pv = s_pv; wr = s_wr; wd = s_wd; rd = s_rd;
    @(posedge clk);
    @(negedge clk);
    st = 0; sp = 0; ld = 0; wr = 0; rd = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] snapv;
    for (int a = 0; a < 64; a++) m_ok[a] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(rdat, 8'h00, "R8 read after reset");
    chk({7'b0, tl}, 8'h00, "R8 strobe after reset");
    cmp_en = 1;

    // fill RAM 8..63; the last write wraps the pointer to 0 (R4)
    live = 64'h8877_6655_4433_2211;
    step(0, 0, 1, 6'd8, 0, 0, 0);
    for (int a = 8; a < 64; a++) step(0, 0, 0, 0, 1, ram_init(a), 0);
    chk(rdat, 8'h11, "R4 wrap snapshot byte0 / R2 wrap to 0");
    step(0, 0, 0, 0, 0, 0, 1);
    chk(rdat, 8'h22, "R4 wrap snapshot byte1");

    // R1: RAM readback
    step(0, 0, 1, 6'h10, 0, 0, 0);
    chk(rdat, ram_init(16), "R1 ram read at 10h");
    step(0, 0, 0, 0, 0, 0, 1);
    chk(rdat, ram_init(17), "R1 ram read at 11h");

    // R3: start snapshot
    live = 64'hA7A6_A5A4_A3A2_A1A0;
    step(0, 0, 1, 6'd0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      chk(rdat, 8'hA0 + 8'(k), "R3 start snapshot");
      step(0, 0, 0, 0, 0, 0, 1);
    end
    // R3: stop snapshot
    live = 64'h3737_3636_3535_3434;
    step(0, 1, 1, 6'd3, 0, 0, 0);
    chk(rdat, 8'h35, "R3 stop snapshot byte3");

    // R5: burst read while live counters tick
    snapv = 64'h0F0E_0D0C_0B0A_0908;
    live = snapv;
    step(1, 0, 1, 6'd0, 0, 0, 0);
    tick_en = 1;
    for (int k = 0; k < 8; k++) begin
      chk(rdat, snapv[k*8 +: 8], "R5 stable burst");
      step(0, 0, 0, 0, 0, 0, 1);
    end
    tick_en = 0;

    // R7: snapshots leave RAM intact
    step(0, 1, 1, 6'h3F, 0, 0, 0);
    chk(rdat, ram_init(63), "R7 ram after snapshot");

    // R6: time write strobe
    step(0, 0, 1, 6'd2, 0, 0, 0);
    step(0, 0, 0, 0, 1, 8'h45, 0);
    chk({7'b0, tl}, 8'h01, "R6 strobe high");
    chk({5'b0, tadr}, 8'h02, "R6 strobe addr");
    chk(tdat, 8'h45, "R6 strobe data");
    step(0, 0, 0, 0, 0, 0, 0);
    chk({7'b0, tl}, 8'h00, "R6 strobe one cycle");
    step(0, 0, 1, 6'd2, 0, 0, 0);
    chk(rdat, 8'h45, "R6 written byte in copy");

    // R9: write and snapshot on the same edge
    live = 64'hB7B6_B5B4_B3B2_B1B0;
    step(0, 0, 1, 6'd5, 0, 0, 0);
    step(1, 0, 0, 0, 1, 8'h77, 0);
    step(0, 0, 1, 6'd4, 0, 0, 0);
    chk(rdat, 8'hB4, "R9 other byte snapped");
    step(0, 0, 0, 0, 0, 0, 1);
    chk(rdat, 8'h77, "R9 written byte wins");
    step(0, 0, 0, 0, 0, 0, 1);
    chk(rdat, 8'hB6, "R9 next byte snapped");

    // R2: load overrides a same-cycle write
    step(0, 0, 1, 6'h18, 0, 0, 0);
    step(0, 0, 1, 6'h20, 1, 8'hEE, 1);
    chk(rdat, ram_init(32), "R2 load wins over access");
    step(0, 0, 1, 6'h18, 0, 0, 0);
    chk(rdat, ram_init(24), "R2 suppressed write left ram");

    // R7: RAM overwrite
    step(0, 0, 0, 0, 1, 8'h5A, 0);
    step(0, 0, 1, 6'h18, 0, 0, 0);
    chk(rdat, 8'h5A, "R7 ram overwrite");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule